// File: doc/BRIEF.md
# Precomputation-Gated Unsigned Comparator

This block decides whether unsigned operand A is greater than unsigned operand B and registers the answer. To cut switching activity, it looks at the top bit of each operand first. When the top bits differ, the top bits alone settle the answer, and the wide comparator over the remaining bits is left idle. In that case the registers feeding the wide comparator keep their old contents, so its inputs do not toggle. Only when the top bits agree do those lower-bit registers load new data and the wide comparison take part in the result.

The top-bit registers load on every clock. A two-way select, steered by the registered equality of the top bits, picks either the shortcut value or the wide comparator output. Both paths have the same latency of one clock. A debug output reports, for each valid result, whether the wide comparison produced it. The block therefore serves as a drop-in registered comparator, and the debug flag shows how often the expensive path is used.

Top module: `precomp_gt`

## Requirements
- R1: After reset, `out_valid`, `a_gt_b` and `full_cmp` are all 0.
- R2: An operand pair presented with `in_valid` high at a rising edge produces its result after that edge, and `out_valid` is high in exactly those cycles. The latency is one cycle on both paths.
- R3: When the top bits (bit W-1) of A and B differ, `a_gt_b` equals A's top bit and `full_cmp` is 0.
- R4: When the top bits of A and B are equal, `a_gt_b` is 1 exactly when A is greater than B as an unsigned number, and `full_cmp` is 1.
- R5: In a cycle where `out_valid` is 0, both `a_gt_b` and `full_cmp` are 0.
- R6: The lower-bit operand registers (bits W-2..0) load only on a valid cycle with equal top bits and hold otherwise. Lower bits supplied during a shortcut or idle cycle never affect a later result.
- R7: Equal operands give `a_gt_b` = 0 with `full_cmp` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `a_in`/`b_in` is to be compared |
| a_in | input | W | Unsigned operand A |
| b_in | input | W | Unsigned operand B |
| out_valid | output | 1 | Result for the pair of the previous cycle is present |
| a_gt_b | output | 1 | Registered result of A > B |
| full_cmp | output | 1 | Result came from the wide lower-bit comparison |

## Verification
The bench sweeps every pair of 8-bit operands back to back. It therefore meets every mix of differing and equal top bits, including equal operands, all-ones against all-zeros, and neighbours that differ only in the lowest bit. Pairs with differing top bits but lower bits that would reverse the answer show whether the shortcut is really taken. Equal-top-bit pairs that follow shortcut cycles with unrelated lower bits show whether stale lower data leaks into a result. Idle gaps between operations separate the valid timing from the result value. The tally of `full_cmp` over the sweep must come out at exactly half of all pairs.

// File: rtl/precomp_gt.sv
module precomp_gt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         out_valid,
  output logic         a_gt_b,
  output logic         full_cmp
);
  localparam int LW = W - 1;

  logic          msb_a_q, msb_b_q, vld_q;
  logic [LW-1:0] lo_a_q, lo_b_q;

  wire msb_eq_in = (a_in[W-1] == b_in[W-1]);
  wire lo_load   = in_valid && msb_eq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_a_q <= 1'b0;
      msb_b_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      msb_a_q <= a_in[W-1];
      msb_b_q <= b_in[W-1];
      vld_q   <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_a_q <= '0;
      lo_b_q <= '0;
    end else if (lo_load) begin
      lo_a_q <= a_in[LW-1:0];
      lo_b_q <= b_in[LW-1:0];
    end
  end

  wire msb_eq_q = (msb_a_q == msb_b_q);
  wire full_gt  = (lo_a_q > lo_b_q);
  wire pick     = msb_eq_q ? full_gt : msb_a_q;

  assign out_valid = vld_q;
  assign a_gt_b    = vld_q & pick;
  assign full_cmp  = vld_q & msb_eq_q;
endmodule

// File: rtl/precomp_gt_chk.sv
module precomp_gt_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   a_in,
  input logic [W-1:0]   b_in,
  input logic           out_valid,
  input logic           a_gt_b,
  input logic           full_cmp,
  input logic [W-2:0]   lo_a_q,
  input logic [W-2:0]   lo_b_q
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_in[W-1] != b_in[W-1])) |=>
      (!full_cmp && (a_gt_b == $past(a_in[W-1]))));
  a_r4_full_path: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_in[W-1] == b_in[W-1])) |=>
      (full_cmp && (a_gt_b == ($past(a_in) > $past(b_in)))));
  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!a_gt_b && !full_cmp));
  a_r6_lower_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (a_in[W-1] == b_in[W-1])) |=>
      ($stable(lo_a_q) && $stable(lo_b_q)));
endmodule

bind precomp_gt precomp_gt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
  .out_valid(out_valid), .a_gt_b(a_gt_b), .full_cmp(full_cmp),
  .lo_a_q(lo_a_q), .lo_b_q(lo_b_q)
);

// File: tb/tb_precomp_gt.sv
module tb_precomp_gt;
  localparam int W = 8;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         out_valid, a_gt_b, full_cmp;

  int checks = 0, errors = 0, full_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  precomp_gt #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .a_gt_b(a_gt_b), .full_cmp(full_cmp)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b);
    bit differ;
    a_in = a; b_in = b; in_valid = 1'b1;
    @(negedge clk);
    differ = (a[W-1] != b[W-1]);
    check("R2 out_valid", out_valid, 1);
    if (differ) begin
      check("R3 shortcut result", a_gt_b, a[W-1]);
      check("R3 full_cmp low", full_cmp, 0);
    end else begin
      check(a == b ? "R7 equal operands" : "R4 full result", a_gt_b, (a > b) ? 1 : 0);
      check("R4 full_cmp high", full_cmp, 1);
    end
    if (full_cmp) full_seen++;
  endtask

  task automatic idle(input logic [W-1:0] a, input logic [W-1:0] b);
    a_in = a; b_in = b; in_valid = 1'b0;
    @(negedge clk);
    check("R2 no valid after idle", out_valid, 0);
    check("R5 result quiet", a_gt_b, 0);
    check("R5 flag quiet", full_cmp, 0);
  endtask

  initial begin
    #1;
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset a_gt_b", a_gt_b, 0);
    check("R1 reset full_cmp", full_cmp, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", out_valid, 0);

    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        op(W'(a), W'(b));
    check("R4 full path share", full_seen, N * N / 2);

    idle(8'hFF, 8'h00);
    // R6: shortcut and idle cycles carry lower bits that would flip a stale compare
    op(8'h05, 8'h06);
    op(8'h7F, 8'h80);
    idle(8'h7F, 8'h00);
    op(8'h80, 8'h7F);
    op(8'h03, 8'h02);
    check("R6 stale lower bits ignored", a_gt_b, 1);
    op(8'h81, 8'h81);
    idle(8'h00, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule